// File: doc/BRIEF.md
# LCD Controller Command Decoder and Display Memory Access Unit

This unit sits between a host bus front end and the display memory of a dot-matrix LCD controller. Every host transfer arrives as one request: a byte, a direction (write or read) and a flag that tells display data from instructions. Instruction writes are decoded into the mode settings that the scan logic uses: display enable, column order, static drive, duty and the first displayed line. They also set the page and column pointers into display memory. Instruction reads return a status byte.

Data writes go straight to the memory at the current page and column. Data reads issue a memory read and return the byte fetched by the read before it, so a host starts a burst with one dummy read. After each data access the column pointer steps forward and stops at the last column. A read-modify-write mode keeps the pointer still on reads, so a host can read a byte, change it and write it back in place. Leaving that mode returns the pointer to the column it held on entry.

Requests use a valid/ready handshake. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` falls only while a read response is waiting and `rsp_ready` is low, so a pending response is never overwritten. A response stays valid, with stable data, until a cycle in which `rsp_ready` is high. The memory port is a plain synchronous port: strobes are single cycles, and read data is due one cycle after `ram_re`.

Top module: `lcd_cmd_ctrl`

## Requirements
- R1: After reset, disp_on, col_rev, static_on, duty32, rmw_active, start_line, ram_page, ram_col and rsp_valid are all 0.
- R2: An accepted instruction write of 0xAE/0xAF, 0xA0/0xA1, 0xA4/0xA5 or 0xA8/0xA9 sets disp_on, col_rev, static_on or duty32 in turn to byte bit 0, visible in the cycle after acceptance.
- R3: Instruction 0xB8+n (n = 0..3) sets ram_page to n, and 0xC0+n (n = 0..31) sets start_line to n, both from the cycle after acceptance.
- R4: An instruction byte with bit 7 clear sets the column to its low 7 bits. Values above 79 become 79. ram_col always shows the current column.
- R5: An accepted data write pulses ram_we in the acceptance cycle, with ram_wdata equal to req_data and ram_page/ram_col equal to the current page and column. The column then steps by one but never goes past 79.
- R6: An accepted data read pulses ram_re at the current page and column. rsp_valid rises in the next cycle, carrying the memory byte of the previous data read (0 if none since reset). Outside read-modify-write mode the column then steps as in R5.
- R7: Instruction 0xE0 raises rmw_active and saves the column. In that mode data reads leave the column unchanged and data writes step it. Instruction 0xEE, while rmw_active is high, restores the saved column and clears rmw_active; outside the mode it changes nothing.
- R8: Instruction 0xE2 clears start_line, ram_page, ram_col and rmw_active, and leaves disp_on, col_rev, static_on and duty32 unchanged.
- R9: An instruction read returns a status byte: bit 7 = 1 if an instruction write was accepted in the cycle before; bit 6 = 1 when col_rev is 0; bit 5 = 1 when disp_on is 0; bit 4 = 1 if the instruction accepted in the cycle before was 0xE2; bits 3..0 = 0.
- R10: While rsp_valid is high and rsp_ready is low, req_ready is low, no memory strobe is issued, and rsp_data stays stable.
- R11: Instruction bytes with bit 7 set that match no command above (for example 0xA2, 0xBC, 0xE3, 0xFF) change no mode, page or column output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_data | input | 1 | 1 = display data, 0 = instruction/status |
| req_data | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte |
| ram_we | output | 1 | Memory write strobe |
| ram_re | output | 1 | Memory read strobe |
| ram_page | output | 2 | Current page |
| ram_col | output | 7 | Current column |
| ram_wdata | output | 8 | Memory write byte |
| ram_rdata | input | 8 | Memory read byte, one cycle after ram_re |
| disp_on | output | 1 | Display enabled |
| col_rev | output | 1 | Reversed column order |
| static_on | output | 1 | Static drive selected |
| duty32 | output | 1 | 1 = 32-line duty, 0 = 16-line duty |
| start_line | output | 5 | First displayed line |
| rmw_active | output | 1 | Read-modify-write mode active |

## Verification
The memory strobes, address and write byte are combinational in the acceptance cycle. The bench drives each request on the falling edge and samples them 1 ns later, before the accepting edge. Mode, page, column and status-flag changes, and read responses, appear one cycle after acceptance, so the bench samples them 1 ns after the accepting rising edge. The dummy-read latency and the busy and reset flags in the status byte are checked with back-to-back requests in the cycles right after an instruction. The stall case holds a request against a refused handshake for two cycles and checks that the response byte stays the same.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_DISP,
    OP_REV,
    OP_STATIC,
    OP_DUTY,
    OP_PAGE,
    OP_COL,
    OP_LINE,
    OP_RMW,
    OP_END,
    OP_RST
  } op_e;

  typedef struct packed {
    op_e        op;
    logic       flag;
    logic [6:0] arg;
  } cmd_t;

  localparam int ST_BUSY = 7;
  localparam int ST_DIR  = 6;
  localparam int ST_OFF  = 5;
  localparam int ST_RST  = 4;

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
  import lcd_cmd_pkg::*;
#(
  parameter int COL_MAX = 79
) (
  input  logic [7:0] byte_i,
  output cmd_t       cmd_o
);
  localparam logic [6:0] LIM = 7'(COL_MAX);

  always_comb begin
    cmd_o.op   = OP_NONE;
    cmd_o.flag = byte_i[0];
    cmd_o.arg  = 7'd0;
    if (!byte_i[7]) begin
      cmd_o.op  = OP_COL;
      cmd_o.arg = (byte_i[6:0] > LIM) ? LIM : byte_i[6:0];
    end else begin
      casez (byte_i)
        8'b1010_111?: cmd_o.op = OP_DISP;
        8'b1010_000?: cmd_o.op = OP_REV;
        8'b1010_010?: cmd_o.op = OP_STATIC;
        8'b1010_100?: cmd_o.op = OP_DUTY;
        8'b1011_10??: begin
          cmd_o.op  = OP_PAGE;
          cmd_o.arg = {5'd0, byte_i[1:0]};
        end
        8'b110?_????: begin
          cmd_o.op  = OP_LINE;
          cmd_o.arg = {2'd0, byte_i[4:0]};
        end
        8'hE0:   cmd_o.op = OP_RMW;
        8'hEE:   cmd_o.op = OP_END;
        8'hE2:   cmd_o.op = OP_RST;
        default: cmd_o.op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_col_ctr.sv
module lcd_col_ctr #(
  parameter int COL_MAX = 79,
  localparam int COL_W  = $clog2(COL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [COL_W-1:0] load_val,
  input  logic             step,
  input  logic             rmw_enter,
  input  logic             rmw_exit,
  output logic [COL_W-1:0] col_o,
  output logic             rmw_o
);
  localparam logic [COL_W-1:0] LIM = COL_W'(COL_MAX);

  logic [COL_W-1:0] saved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_o   <= '0;
      saved_q <= '0;
      rmw_o   <= 1'b0;
    end else begin
      if (rmw_enter) begin
        saved_q <= col_o;
        rmw_o   <= 1'b1;
      end
      if (clear) begin
        col_o <= '0;
        rmw_o <= 1'b0;
      end else if (load) begin
        col_o <= load_val;
      end else if (rmw_exit && rmw_o) begin
        col_o <= saved_q;
        rmw_o <= 1'b0;
      end else if (step && col_o != LIM) begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  p_col_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_o <= LIM);

  p_col_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !load && !rmw_exit && col_o < LIM)
      |=> col_o == $past(col_o) + 1'b1);

  p_col_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && !load && !rmw_exit && col_o == LIM) |=> col_o == LIM);

  p_rmw_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rmw_enter && !clear) |=> rmw_o);
endmodule

// File: rtl/lcd_rd_path.sv
module lcd_rd_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_rd,
  input  logic          rd_is_data,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] ram_rdata,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic          pend_q;
  logic [DW-1:0] latch_q;
  logic [DW-1:0] prev_byte;

  assign prev_byte = pend_q ? ram_rdata : latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      latch_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      pend_q <= accept_rd && rd_is_data;
      if (pend_q) latch_q <= ram_rdata;
      if (accept_rd) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_is_data ? prev_byte : status_i;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));

  p_rsp_due_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_rd |=> rsp_valid);
endmodule

// File: rtl/lcd_cmd_ctrl.sv
module lcd_cmd_ctrl
  import lcd_cmd_pkg::*;
#(
  parameter int COL_MAX = 79,
  parameter int PAGES   = 4,
  parameter int LINES   = 32,
  parameter int DW      = 8,
  localparam int COL_W  = $clog2(COL_MAX + 1),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_is_data,
  input  logic [DW-1:0]     req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_data,
  output logic              ram_we,
  output logic              ram_re,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_col,
  output logic [DW-1:0]     ram_wdata,
  input  logic [DW-1:0]     ram_rdata,
  output logic              disp_on,
  output logic              col_rev,
  output logic              static_on,
  output logic              duty32,
  output logic [LINE_W-1:0] start_line,
  output logic              rmw_active
);
  cmd_t          cmd;
  logic          accept, instr_wr, accept_rd, busy_q, rstf_q;
  logic [DW-1:0] status;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign instr_wr  = accept && req_write && !req_is_data;
  assign accept_rd = accept && !req_write;
  assign ram_we    = accept && req_write && req_is_data;
  assign ram_re    = accept_rd && req_is_data;
  assign ram_wdata = req_data;

  lcd_cmd_decode #(.COL_MAX(COL_MAX)) u_dec (
    .byte_i (req_data[7:0]),
    .cmd_o  (cmd)
  );

  lcd_col_ctr #(.COL_MAX(COL_MAX)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (instr_wr && cmd.op == OP_RST),
    .load      (instr_wr && cmd.op == OP_COL),
    .load_val  (cmd.arg[COL_W-1:0]),
    .step      (ram_we || (ram_re && !rmw_active)),
    .rmw_enter (instr_wr && cmd.op == OP_RMW),
    .rmw_exit  (instr_wr && cmd.op == OP_END),
    .col_o     (ram_col),
    .rmw_o     (rmw_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_on    <= 1'b0;
      col_rev    <= 1'b0;
      static_on  <= 1'b0;
      duty32     <= 1'b0;
      ram_page   <= '0;
      start_line <= '0;
      busy_q     <= 1'b0;
      rstf_q     <= 1'b0;
    end else begin
      busy_q <= instr_wr;
      rstf_q <= instr_wr && cmd.op == OP_RST;
      if (instr_wr) begin
        case (cmd.op)
          OP_DISP:   disp_on    <= cmd.flag;
          OP_REV:    col_rev    <= cmd.flag;
          OP_STATIC: static_on  <= cmd.flag;
          OP_DUTY:   duty32     <= cmd.flag;
          OP_PAGE:   ram_page   <= cmd.arg[PAGE_W-1:0];
          OP_LINE:   start_line <= cmd.arg[LINE_W-1:0];
          OP_RST: begin
            ram_page   <= '0;
            start_line <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy_q;
    status[ST_DIR]  = !col_rev;
    status[ST_OFF]  = !disp_on;
    status[ST_RST]  = rstf_q;
  end

  lcd_rd_path #(.DW(DW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_rd  (accept_rd),
    .rd_is_data (req_is_data),
    .status_i   (status),
    .ram_rdata  (ram_rdata),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  p_no_strobe_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !ram_we && !ram_re);

  p_ignored_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_wr && cmd.op == OP_NONE) |=> $stable(disp_on) && $stable(col_rev)
      && $stable(static_on) && $stable(duty32) && $stable(ram_page)
      && $stable(start_line) && $stable(ram_col));

  p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_wr && cmd.op == OP_RST) |=> start_line == '0 && ram_page == '0
      && ram_col == '0 && !rmw_active && $stable(disp_on));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
endmodule

// File: tb/lcd_cmd_ctrl_bench.sv
module lcd_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_is_data = 0, rsp_ready = 1;
  logic [7:0] req_data = 0;
  logic req_ready, rsp_valid, ram_we, ram_re;
  logic [7:0] rsp_data, ram_wdata, ram_rdata;
  logic [1:0] ram_page;
  logic [6:0] ram_col;
  logic disp_on, col_rev, static_on, duty32, rmw_active;
  logic [4:0] start_line;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic [7:0] mem [4][80];
  logic [7:0] rdq = 0;

  // bench state model
  int m_col = 0, m_page = 0, m_saved = 0;
  bit m_rmw = 0;
  logic [7:0] last_rd = 0;

  // sampled values of the last transfer
  logic s_we, s_re, s_vld;
  logic [6:0] s_col;
  logic [1:0] s_page;
  logic [7:0] s_wd, s_rsp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_cmd_ctrl u_lcd_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_is_data(req_is_data), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ram_we(ram_we), .ram_re(ram_re), .ram_page(ram_page), .ram_col(ram_col),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .disp_on(disp_on),
    .col_rev(col_rev), .static_on(static_on), .duty32(duty32),
    .start_line(start_line), .rmw_active(rmw_active)
  );

  assign ram_rdata = rdq;
  always @(posedge clk) begin
    if (ram_we) mem[ram_page][ram_col] <= ram_wdata;
    if (ram_re) rdq <= mem[ram_page][ram_col];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input bit dat, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_is_data = dat; req_data = d;
    #1;
    s_we = ram_we; s_re = ram_re; s_col = ram_col; s_page = ram_page; s_wd = ram_wdata;
    @(posedge clk); #1;
    req_valid = 0;
    s_vld = rsp_valid; s_rsp = rsp_data;
  endtask

  task automatic instr(input logic [7:0] b);
    xfer(1, 0, b);
    if (!b[7]) m_col = (b[6:0] > 79) ? 79 : int'(b[6:0]);
    else if (b[7:2] == 6'b101110) m_page = int'(b[1:0]);
    else if (b == 8'hE0) begin m_rmw = 1; m_saved = m_col; end
    else if (b == 8'hEE && m_rmw) begin m_rmw = 0; m_col = m_saved; end
    else if (b == 8'hE2) begin m_rmw = 0; m_col = 0; m_page = 0; end
  endtask

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'((p * 80 + c) * 37 + 11);
  endfunction

  task automatic dwrite(input logic [7:0] d, input string req);
    xfer(1, 1, d);
    chk({req, " we"}, s_we, 1);
    chk({req, " col"}, s_col, m_col);
    chk({req, " wdata"}, s_wd, d);
    if (m_col < 79) m_col++;
  endtask

  task automatic dread(input string req);
    logic [7:0] exp;
    exp = last_rd;
    xfer(0, 1, 8'h00);
    chk({req, " re"}, s_re, 1);
    chk({req, " col"}, s_col, m_col);
    chk({req, " rsp_valid"}, s_vld, 1);
    chk({req, " dummy-read data"}, s_rsp, exp);
    last_rd = mem[m_page][m_col];
    if (!m_rmw && m_col < 79) m_col++;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 80; c++) mem[p][c] = 8'h00;
    #(3*CLK_PERIOD) rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 disp_on", disp_on, 0);
    chk("R1 col_rev", col_rev, 0);
    chk("R1 static_on", static_on, 0);
    chk("R1 duty32", duty32, 0);
    chk("R1 rmw_active", rmw_active, 0);
    chk("R1 start_line", start_line, 0);
    chk("R1 ram_page", ram_page, 0);
    chk("R1 ram_col", ram_col, 0);
    chk("R1 rsp_valid", rsp_valid, 0);

    // R2 mode commands, both settings each
    for (int v = 0; v < 4; v++) begin
      instr(8'hAE | 8'(v & 1));      chk("R2 disp_on", disp_on, v & 1);
      instr(8'hA0 | 8'(v >> 1));     chk("R2 col_rev", col_rev, v >> 1);
      instr(8'hA4 | 8'(v & 1));      chk("R2 static_on", static_on, v & 1);
      instr(8'hA8 | 8'((v >> 1) ^ 1)); chk("R2 duty32", duty32, (v >> 1) ^ 1);
    end

    // R3 start line and page sweeps
    for (int n = 0; n < 32; n++) begin
      instr(8'hC0 + 8'(n)); chk("R3 start_line", start_line, n);
    end
    for (int n = 0; n < 4; n++) begin
      instr(8'hB8 + 8'(n)); chk("R3 ram_page", ram_page, n);
    end

    // R4 column set sweep with clamping
    for (int n = 0; n < 128; n++) begin
      instr(8'(n)); chk("R4 ram_col", ram_col, (n > 79) ? 79 : n);
    end

    // R5 fill all pages, saturation at the last column
    for (int p = 0; p < 4; p++) begin
      instr(8'hB8 + 8'(p));
      instr(8'h00);
      for (int c = 0; c < 80; c++) begin
        dwrite(pat(p, c), "R5");
        chk("R5 page", s_page, p);
      end
      chk("R5 saturated col", ram_col, 79);
      dwrite(pat(p, 79), "R5 at limit");
      chk("R5 col stays", ram_col, 79);
    end

    // R6 read back with dummy-read pipeline
    for (int p = 3; p >= 0; p--) begin
      instr(8'hB8 + 8'(p));
      instr(8'h00);
      for (int k = 0; k < 81; k++) dread("R6");
      chk("R6 col after burst", ram_col, 79);
    end

    // R7 read-modify-write
    instr(8'hB9); instr(8'd10);
    instr(8'hE0);
    chk("R7 rmw_active", rmw_active, 1);
    for (int k = 0; k < 3; k++) dread("R7 read holds col");
    chk("R7 col after reads", ram_col, 10);
    dwrite(8'h3C, "R7 write steps");
    dwrite(8'hC3, "R7 write steps");
    chk("R7 col after writes", ram_col, 12);
    instr(8'hEE);
    chk("R7 restored col", ram_col, 10);
    chk("R7 mode left", rmw_active, 0);
    instr(8'd5);
    instr(8'hEE);
    chk("R7 END outside mode", ram_col, 5);
    dread("R7 reads step again");
    chk("R7 col stepped", ram_col, 6);

    // R9 status byte over direction/enable combos
    for (int v = 0; v < 4; v++) begin
      instr(8'hAE | 8'(v & 1));
      instr(8'hA0 | 8'(v >> 1));
      xfer(0, 0, 8'h00);
      chk("R9 status after instr", s_rsp,
          128 + (((v >> 1) == 0) ? 64 : 0) + (((v & 1) == 0) ? 32 : 0));
      xfer(0, 0, 8'h00);
      chk("R9 status idle", s_rsp,
          (((v >> 1) == 0) ? 64 : 0) + (((v & 1) == 0) ? 32 : 0));
    end

    // R8 software reset keeps modes
    instr(8'hAF); instr(8'hA1); instr(8'hA5); instr(8'hA9);
    instr(8'hC7); instr(8'hBA); instr(8'd30); instr(8'hE0);
    instr(8'hE2);
    chk("R8 start_line", start_line, 0);
    chk("R8 ram_page", ram_page, 0);
    chk("R8 ram_col", ram_col, 0);
    chk("R8 rmw_active", rmw_active, 0);
    chk("R8 modes kept", {disp_on, col_rev, static_on, duty32}, 15);
    xfer(0, 0, 8'h00);
    chk("R9 status after reset cmd", s_rsp, 128 + 16);

    // R11 undefined bytes
    instr(8'hC3); instr(8'hBB); instr(8'd44);
    begin
      logic [7:0] undef [4] = '{8'hA2, 8'hBC, 8'hE3, 8'hFF};
      for (int k = 0; k < 4; k++) begin
        instr(undef[k]);
        chk("R11 modes", {disp_on, col_rev, static_on, duty32}, 15);
        chk("R11 start_line", start_line, 3);
        chk("R11 page", ram_page, 3);
        chk("R11 col", ram_col, 44);
      end
    end

    // R10 stall on pending response
    rsp_ready = 0;
    xfer(0, 1, 8'h00);
    last_rd = mem[m_page][m_col];
    if (m_col < 79) m_col++;
    chk("R10 rsp_valid", s_vld, 1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_is_data = 1; req_data = 8'h77;
    #1;
    chk("R10 ready low", req_ready, 0);
    chk("R10 no strobe", ram_we, 0);
    s_rsp = rsp_data;
    @(negedge clk); #1;
    chk("R10 still no strobe", ram_we, 0);
    chk("R10 rsp stable", rsp_data, s_rsp);
    chk("R10 col unchanged", ram_col, m_col);
    rsp_ready = 1;
    #1;
    chk("R10 ready back", req_ready, 1);
    chk("R10 strobe on accept", ram_we, 1);
    @(posedge clk); #1;
    req_valid = 0;
    if (m_col < 79) m_col++;
    chk("R10 col after accept", ram_col, m_col);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule